// File: doc/BRIEF.md
# GPIO Bank with Two Interrupt Banks

This block controls 32 general-purpose lines through a 32-bit register port. Each line has a direction bit, a stored output value and a synchronized input sample. Lines set as inputs are watched for four kinds of event: rising edge, falling edge, high level and low level. Every event sets the line's bit in two separate status registers. Each status register has its own enable mask and drives its own interrupt output, so two consumers can each mask and acknowledge events without affecting the other.

Status bits are cleared by writing ones. Any line that still sits at an enabled level is set again on the next cycle, so a level condition cannot be lost by acknowledging it. The enable masks, the wakeup mask and the output data each have companion addresses that set or clear only the bits written as 1. A wakeup request is raised when an event meets the wakeup conditions, and it stays high until a reset. Debounce settings are stored and can be read back, but they do not filter the inputs.

Top module: `gpio_bank`

## Requirements
- R1: After a hardware reset, reads return the following. Address 0x00 returns 0x18 and 0x14 returns 1. The control register at 0x30 returns 2 and the direction register at 0x34 returns 0xFFFFFFFF. Every other mapped register returns 0. `pad_oe`, `irq_a`, `irq_b` and `wake_req` are all 0.
- R2: A read is a one-cycle access: `bus_rdata` holds the value of the addressed register after the clock edge that samples the request.
  - The sysconfig register at 0x10 stores the written value ANDed with 0x1D.
  - Control keeps only bits 2:0, and the debounce time at 0x54 keeps only bits 7:0.
  - The masks at 0x1C, 0x2C and 0x20, data-out at 0x3C, the detect registers at 0x40/0x44/0x48/0x4C and debounce enable at 0x50 store all 32 bits.
  - Writes to 0x00, 0x14, 0x38 or an unmapped address change nothing.
  - Unmapped reads return 0.
- R3: Each of the following registers has an address that clears the bits written as 1 and an address that sets them:
  - enable-A (0x1C): clear 0x60, set 0x64.
  - enable-B (0x2C): clear 0x70, set 0x74.
  - wakeup mask (0x20): clear 0x80, set 0x84.
  - data-out (0x3C): clear 0x90, set 0x94.
  Reading any of these alias addresses returns the underlying register.
- R4: A direction bit of 0 makes the line an output. `pad_oe` is the inverse of the direction register. `pad_out` carries data-out on output lines and 0 on input lines. A line switched to output shows its stored data-out value at once.
- R5: On an input line, a 0-to-1 change of the synchronized input raises an event when rise-detect (0x48) or high-level detect (0x44) is set for that line. A 1-to-0 change raises an event when fall-detect (0x4C) or low-level detect (0x40) is set.
- R6: Lines whose direction bit is 0 never raise events or set status bits.
- R7: An event sets the line's bit in both status-A (0x18) and status-B (0x28). `irq_a` is high when status-A AND enable-A is nonzero. `irq_b` is high when status-B AND enable-B is nonzero.
- R8: Writing a status register clears the bits written as 1 and leaves the others and the other status register unchanged. One cycle later, status bits are set again for every input line that is high with high-level detect enabled or low with low-level detect enabled.
- R9: A write to either level-detect register or to the direction register triggers the same level re-evaluation in both status registers one cycle later.
- R10: `wake_req` rises on an event only when all three of these hold: sysconfig bit 2 is 1, sysconfig bits 4:3 are nonzero, and the line's wakeup-mask bit is 1. Once high, it stays high until a soft or hardware reset.
- R11: A sysconfig write with bit 1 set is a soft reset. It restores every register to its hardware reset value except data-out, which is kept, and it clears `wake_req`. The sysconfig register then holds the written value ANDed with 0x1D.
- R12: `pad_in` passes through two flops before it is used. A read of data-in (0x38) that is sampled at the second clock edge after a pad change still returns the old value. A read sampled at the third edge returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pad_in | input | 32 | Asynchronous line inputs |
| pad_out | output | 32 | Output values, zero on input lines |
| pad_oe | output | 32 | 1 where the line is driven as output |
| irq_a | output | 1 | Masked interrupt from status-A |
| irq_b | output | 1 | Masked interrupt from status-B |
| wake_req | output | 1 | Sticky wakeup request |

## Verification
The hardest situation to reach is the interaction between a status clear and a level that is still active, where the bit must come back one cycle after it was cleared. The same holds when a level or direction write, rather than a pad change, is what makes a condition true. The bench sweeps every detect kind over several lines through a fixed rise-clear-fall-clear script, so each kind meets both a stale level and a fresh edge. It also re-reads status after clearing it, without any pad activity. Wakeup is swept over all eight combinations of its three enabling conditions, and its stickiness is checked across pad changes and status clears.

// File: rtl/gpio_bank_pkg.sv
// Package: register addresses, reset constants and update-mode encoding
// shared by the GPIO bank and its submodules.
package gpio_bank_pkg;

    localparam logic [7:0] A_REV      = 8'h00;
    localparam logic [7:0] A_SYSCFG   = 8'h10;
    localparam logic [7:0] A_SYSSTAT  = 8'h14;
    localparam logic [7:0] A_STAT_A   = 8'h18;
    localparam logic [7:0] A_EN_A     = 8'h1C;
    localparam logic [7:0] A_WKEN     = 8'h20;
    localparam logic [7:0] A_STAT_B   = 8'h28;
    localparam logic [7:0] A_EN_B     = 8'h2C;
    localparam logic [7:0] A_CTRL     = 8'h30;
    localparam logic [7:0] A_DIR      = 8'h34;
    localparam logic [7:0] A_DIN      = 8'h38;
    localparam logic [7:0] A_DOUT     = 8'h3C;
    localparam logic [7:0] A_LVL_LO   = 8'h40;
    localparam logic [7:0] A_LVL_HI   = 8'h44;
    localparam logic [7:0] A_RISE     = 8'h48;
    localparam logic [7:0] A_FALL     = 8'h4C;
    localparam logic [7:0] A_DB_EN    = 8'h50;
    localparam logic [7:0] A_DB_TIME  = 8'h54;
    localparam logic [7:0] A_EN_A_CLR = 8'h60;
    localparam logic [7:0] A_EN_A_SET = 8'h64;
    localparam logic [7:0] A_EN_B_CLR = 8'h70;
    localparam logic [7:0] A_EN_B_SET = 8'h74;
    localparam logic [7:0] A_WK_CLR   = 8'h80;
    localparam logic [7:0] A_WK_SET   = 8'h84;
    localparam logic [7:0] A_DOUT_CLR = 8'h90;
    localparam logic [7:0] A_DOUT_SET = 8'h94;

    localparam logic [7:0] REV_VALUE    = 8'h18;
    localparam logic [4:0] SYSCFG_KEEP  = 5'h1D;
    localparam logic [2:0] CTRL_RESET   = 3'd2;
    localparam int         SOFT_RST_BIT = 1;

    // Plain full-width registers, index order used by the generate loop.
    localparam int NPLAIN   = 6;
    localparam int PL_DIR   = 0;
    localparam int PL_LVLLO = 1;
    localparam int PL_LVLHI = 2;
    localparam int PL_RISE  = 3;
    localparam int PL_FALL  = 4;
    localparam int PL_DBEN  = 5;

    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_LOAD = 2'd1,
        UPD_CLR  = 2'd2,
        UPD_SET  = 2'd3
    } upd_e;

    function automatic logic [7:0] plain_addr(input int idx);
        case (idx)
            PL_DIR:   return A_DIR;
            PL_LVLLO: return A_LVL_LO;
            PL_LVLHI: return A_LVL_HI;
            PL_RISE:  return A_RISE;
            PL_FALL:  return A_FALL;
            default:  return A_DB_EN;
        endcase
    endfunction

    function automatic logic [7:0] stat_addr(input int bank);
        return (bank == 0) ? A_STAT_A : A_STAT_B;
    endfunction

    function automatic logic [7:0] en_addr(input int bank);
        return (bank == 0) ? A_EN_A : A_EN_B;
    endfunction

    function automatic logic [7:0] en_clr_addr(input int bank);
        return (bank == 0) ? A_EN_A_CLR : A_EN_B_CLR;
    endfunction

    function automatic logic [7:0] en_set_addr(input int bank);
        return (bank == 0) ? A_EN_A_SET : A_EN_B_SET;
    endfunction

    // Chooses the update mode from three decoded write strobes.
    function automatic upd_e pick_upd(input logic ld, input logic clr, input logic set);
        if (ld)       return UPD_LOAD;
        else if (clr) return UPD_CLR;
        else if (set) return UPD_SET;
        else          return UPD_NONE;
    endfunction

endpackage

// File: rtl/gpio_alias_reg.sv
// gpio_alias_reg: one register that can be loaded, or have bits set or
// cleared by a one-hot mask. Assumes at most one update mode per cycle;
// a soft reset optionally returns it to its reset value.
module gpio_alias_reg
    import gpio_bank_pkg::*;
#(
    parameter int         W           = 32,
    parameter logic [W-1:0] RST_VAL   = '0,
    parameter bit         SOFT_CLEARS = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  upd_e         upd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Register update: reset, soft reset, then load / clear / set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (soft_rst && SOFT_CLEARS) begin
            q <= RST_VAL;
        end else begin
            case (upd)
                UPD_LOAD: q <= wdata;
                UPD_CLR:  q <= q & ~wdata;
                UPD_SET:  q <= q | wdata;
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// gpio_in_sync: two-flop synchronizer on every line, followed by a
// previous-sample flop. Assumes pad inputs are asynchronous to clk.
// Edge pulses last one cycle and refer to the synchronized value.
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // Synchronizer chain and previous-sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge extraction from current and previous synchronized samples.
    always_comb begin
        level = sync_q;
        rise  = sync_q & ~prev_q;
        fall  = ~sync_q & prev_q;
    end

endmodule

// File: rtl/gpio_irq_bank.sv
// gpio_irq_bank: one interrupt status register with its enable mask.
// Assumes event_vec and level_hit are already qualified by direction.
// Status is set by events, cleared by write-one, and re-armed from
// level_hit one cycle after a status write or an external request.
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] event_vec,
    input  logic [W-1:0] level_hit,
    input  logic         reeval_req,
    input  logic         stat_wr,
    input  upd_e         en_upd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] enable,
    output logic         irq
);

    logic reeval_q;

    // Remembers that the level conditions must be re-applied next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        reeval_q <= 1'b0;
        else if (soft_rst) reeval_q <= 1'b0;
        else               reeval_q <= reeval_req | stat_wr;
    end

    // Status update: write-one clear, then events and level re-arm win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else if (soft_rst) begin
            status <= '0;
        end else begin
            status <= (stat_wr ? (status & ~wdata) : status)
                    | event_vec
                    | (reeval_q ? level_hit : '0);
        end
    end

    gpio_alias_reg #(
        .W           (W),
        .RST_VAL     ('0),
        .SOFT_CLEARS (1'b1)
    ) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .upd      (en_upd),
        .wdata    (wdata),
        .q        (enable)
    );

    // Interrupt line: any status bit that is also enabled.
    always_comb irq = |(status & enable);

endmodule

// File: rtl/gpio_bank.sv
// gpio_bank: register-mapped bank of NLINES general-purpose lines with
// two independently masked interrupt status banks and a sticky wakeup.
// Assumes NLINES <= DW, single-cycle register accesses, and a
// synchronous active-low reset. Debounce values are storage only.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int DW     = 32,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    output logic              irq_a,
    output logic              irq_b,
    output logic              wake_req
);

    localparam int NBANK = 2;

    logic              wr_en;
    logic              rd_en;
    logic              soft_rst;
    logic [NLINES-1:0] line_wd;

    logic [4:0]        sysconfig_q;
    logic [2:0]        ctrl_q;
    logic [7:0]        db_time_q;
    logic [NLINES-1:0] plain_q [NPLAIN];
    logic [NLINES-1:0] wken_q;
    logic [NLINES-1:0] dout_q;
    logic              wake_q;

    logic [NLINES-1:0] din;
    logic [NLINES-1:0] rise;
    logic [NLINES-1:0] fall;
    logic [NLINES-1:0] dir;
    logic [NLINES-1:0] evt;
    logic [NLINES-1:0] lvl_hit;
    logic              reeval_req;
    logic              wake_cond;

    logic [NLINES-1:0] status_q [NBANK];
    logic [NLINES-1:0] enable_q [NBANK];
    logic [NBANK-1:0]  irq_vec;
    logic [DW-1:0]     rd_val;

    // Access decode and soft reset strobe.
    always_comb begin
        wr_en    = bus_sel && bus_wr;
        rd_en    = bus_sel && !bus_wr;
        line_wd  = bus_wdata[NLINES-1:0];
        soft_rst = wr_en && (bus_addr == AW'(A_SYSCFG)) && bus_wdata[SOFT_RST_BIT];
    end

    // Sysconfig keeps only its defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sysconfig_q <= '0;
        else if (wr_en && bus_addr == AW'(A_SYSCFG))
            sysconfig_q <= bus_wdata[4:0] & SYSCFG_KEEP;
    end

    // Control and debounce time: narrow registers cleared by soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_q    <= CTRL_RESET;
            db_time_q <= '0;
        end else if (wr_en) begin
            if (bus_addr == AW'(A_CTRL))    ctrl_q    <= bus_wdata[2:0];
            if (bus_addr == AW'(A_DB_TIME)) db_time_q <= bus_wdata[7:0];
        end
    end

    // Full-width load-only registers (direction, detect, debounce enable).
    for (genvar i = 0; i < NPLAIN; i++) begin : g_plain
        gpio_alias_reg #(
            .W           (NLINES),
            .RST_VAL     ((i == PL_DIR) ? {NLINES{1'b1}} : {NLINES{1'b0}}),
            .SOFT_CLEARS (1'b1)
        ) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .upd      ((wr_en && bus_addr == AW'(plain_addr(i))) ? UPD_LOAD : UPD_NONE),
            .wdata    (line_wd),
            .q        (plain_q[i])
        );
    end

    gpio_alias_reg #(
        .W           (NLINES),
        .RST_VAL     ('0),
        .SOFT_CLEARS (1'b1)
    ) u_wken (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .upd      (pick_upd(wr_en && bus_addr == AW'(A_WKEN),
                            wr_en && bus_addr == AW'(A_WK_CLR),
                            wr_en && bus_addr == AW'(A_WK_SET))),
        .wdata    (line_wd),
        .q        (wken_q)
    );

    gpio_alias_reg #(
        .W           (NLINES),
        .RST_VAL     ('0),
        .SOFT_CLEARS (1'b0)
    ) u_dout (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .upd      (pick_upd(wr_en && bus_addr == AW'(A_DOUT),
                            wr_en && bus_addr == AW'(A_DOUT_CLR),
                            wr_en && bus_addr == AW'(A_DOUT_SET))),
        .wdata    (line_wd),
        .q        (dout_q)
    );

    gpio_in_sync #(
        .W (NLINES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .level  (din),
        .rise   (rise),
        .fall   (fall)
    );

    // Event and level-condition detection, gated to input lines.
    always_comb begin
        dir     = plain_q[PL_DIR];
        evt     = dir & ((rise & (plain_q[PL_RISE] | plain_q[PL_LVLHI]))
                       | (fall & (plain_q[PL_FALL] | plain_q[PL_LVLLO])));
        lvl_hit = dir & ((din & plain_q[PL_LVLHI]) | (~din & plain_q[PL_LVLLO]));
        reeval_req = wr_en && (bus_addr == AW'(A_LVL_LO) ||
                               bus_addr == AW'(A_LVL_HI) ||
                               bus_addr == AW'(A_DIR));
        wake_cond  = sysconfig_q[2] && (|sysconfig_q[4:3]) && (|(evt & wken_q));
    end

    // Two interrupt banks fed by the same events.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        gpio_irq_bank #(
            .W (NLINES)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_rst   (soft_rst),
            .event_vec  (evt),
            .level_hit  (lvl_hit),
            .reeval_req (reeval_req),
            .stat_wr    (wr_en && bus_addr == AW'(stat_addr(b))),
            .en_upd     (pick_upd(wr_en && bus_addr == AW'(en_addr(b)),
                                  wr_en && bus_addr == AW'(en_clr_addr(b)),
                                  wr_en && bus_addr == AW'(en_set_addr(b)))),
            .wdata      (line_wd),
            .status     (status_q[b]),
            .enable     (enable_q[b]),
            .irq        (irq_vec[b])
        );
    end

    // Sticky wakeup request, cleared only by a reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) wake_q <= 1'b0;
        else if (wake_cond)     wake_q <= 1'b1;
    end

    // Read multiplexer; alias addresses return their underlying register.
    always_comb begin
        rd_val = '0;
        case (bus_addr)
            AW'(A_REV):      rd_val[7:0]        = REV_VALUE;
            AW'(A_SYSCFG):   rd_val[4:0]        = sysconfig_q;
            AW'(A_SYSSTAT):  rd_val[0]          = 1'b1;
            AW'(A_STAT_A):   rd_val[NLINES-1:0] = status_q[0];
            AW'(A_STAT_B):   rd_val[NLINES-1:0] = status_q[1];
            AW'(A_EN_A),
            AW'(A_EN_A_CLR),
            AW'(A_EN_A_SET): rd_val[NLINES-1:0] = enable_q[0];
            AW'(A_EN_B),
            AW'(A_EN_B_CLR),
            AW'(A_EN_B_SET): rd_val[NLINES-1:0] = enable_q[1];
            AW'(A_WKEN),
            AW'(A_WK_CLR),
            AW'(A_WK_SET):   rd_val[NLINES-1:0] = wken_q;
            AW'(A_CTRL):     rd_val[2:0]        = ctrl_q;
            AW'(A_DIR):      rd_val[NLINES-1:0] = plain_q[PL_DIR];
            AW'(A_DIN):      rd_val[NLINES-1:0] = din;
            AW'(A_DOUT),
            AW'(A_DOUT_CLR),
            AW'(A_DOUT_SET): rd_val[NLINES-1:0] = dout_q;
            AW'(A_LVL_LO):   rd_val[NLINES-1:0] = plain_q[PL_LVLLO];
            AW'(A_LVL_HI):   rd_val[NLINES-1:0] = plain_q[PL_LVLHI];
            AW'(A_RISE):     rd_val[NLINES-1:0] = plain_q[PL_RISE];
            AW'(A_FALL):     rd_val[NLINES-1:0] = plain_q[PL_FALL];
            AW'(A_DB_EN):    rd_val[NLINES-1:0] = plain_q[PL_DBEN];
            AW'(A_DB_TIME):  rd_val[7:0]        = db_time_q;
            default:         rd_val             = '0;
        endcase
    end

    // Registered read data, updated on each read request.
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_val;
    end

    // Output qualification by direction.
    always_comb begin
        pad_oe   = ~dir;
        pad_out  = dout_q & ~dir;
        irq_a    = irq_vec[0];
        irq_b    = irq_vec[1];
        wake_req = wake_q;
    end

endmodule

// File: rtl/gpio_bank_chk.sv
// gpio_bank_chk: port-level temporal checks for gpio_bank, bound to it.
// Assumes the synchronous active-low reset is held for at least one edge.
module gpio_bank_chk #(
    parameter int NLINES = 32,
    parameter int DW     = 32,
    parameter int AW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic [NLINES-1:0] pad_out,
    input logic [NLINES-1:0] pad_oe,
    input logic              irq_a,
    input logic              irq_b,
    input logic              wake_req
);

    logic soft_wr;
    logic any_wr;
    always_comb begin
        any_wr  = bus_sel && bus_wr;
        soft_wr = any_wr && (bus_addr == AW'(8'h10)) && bus_wdata[1];
    end

    // R10
    wake_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !soft_wr) |=> wake_req);

    // R11
    soft_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_wr |=> (!wake_req && !irq_a && !irq_b && pad_oe == '0));

    // R2
    rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == AW'(8'h00)) |=> bus_rdata == DW'(32'h18));

    // R2
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == AW'(8'hFC)) |=> bus_rdata == '0);

    // R4
    pad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> ($stable(pad_out) && $stable(pad_oe)));

    // R7
    irq_a_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_a) |-> $past(any_wr));

    // R7
    irq_b_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_b) |-> $past(any_wr));

endmodule

bind gpio_bank gpio_bank_chk #(
    .NLINES (NLINES),
    .DW     (DW),
    .AW     (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_a     (irq_a),
    .irq_b     (irq_b),
    .wake_req  (wake_req)
);

// File: tb/tb_gpio_bank.sv
// tb_gpio_bank: self-checking sweeps over detect kinds, lines, alias
// registers and wakeup conditions, with expected values computed here.
module tb_gpio_bank;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq_a;
    logic        irq_b;
    logic        wake_req;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq_a     (irq_a),
        .irq_b     (irq_b),
        .wake_req  (wake_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic pins(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic soft_reset();
        wr(8'h10, 32'h2);
    endtask

    // Clears both status registers and waits for the level re-arm.
    task automatic clr_all();
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
        bus_wdata = '0; pad_in = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 irq_a", {31'b0, irq_a}, 32'h0);
        chk("R1 irq_b", {31'b0, irq_b}, 32'h0);
        chk("R1 wake", {31'b0, wake_req}, 32'h0);
        rchk("R1 revision", 8'h00, 32'h18);
        rchk("R1 sysstatus", 8'h14, 32'h1);
        rchk("R1 control", 8'h30, 32'h2);
        rchk("R1 direction", 8'h34, 32'hFFFF_FFFF);
        for (int i = 0; i < 13; i++) begin
            logic [7:0] a;
            case (i)
                0: a = 8'h10;  1: a = 8'h18;  2: a = 8'h1C;  3: a = 8'h20;
                4: a = 8'h28;  5: a = 8'h2C;  6: a = 8'h3C;  7: a = 8'h40;
                8: a = 8'h44;  9: a = 8'h48; 10: a = 8'h4C; 11: a = 8'h50;
                default: a = 8'h54;
            endcase
            rchk($sformatf("R1 zero @%h", a), a, 32'h0);
        end

        // R2 read/write sweep over patterns
        for (int p = 0; p < 4; p++) begin
            logic [31:0] pat;
            pat = (p == 0) ? 32'hA5A5_A5A5 : (p == 1) ? 32'h5A5A_5A5A :
                  (p == 2) ? 32'hFFFF_FFFF : 32'h0;
            for (int i = 0; i < 10; i++) begin
                logic [7:0] a;
                case (i)
                    0: a = 8'h1C; 1: a = 8'h2C; 2: a = 8'h20; 3: a = 8'h3C;
                    4: a = 8'h40; 5: a = 8'h44; 6: a = 8'h48; 7: a = 8'h4C;
                    8: a = 8'h50; default: a = 8'h34;
                endcase
                wr(a, pat);
                rchk($sformatf("R2 full @%h", a), a, pat);
            end
            wr(8'h54, pat);
            rchk("R2 debounce time", 8'h54, pat & 32'hFF);
            wr(8'h30, pat);
            rchk("R2 control", 8'h30, pat & 32'h7);
            wr(8'h10, pat & ~32'h2);
            rchk("R2 sysconfig", 8'h10, pat & 32'h1D);
        end
        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h38, 32'hFFFF_FFFF);
        rchk("R2 data-in read-only", 8'h38, 32'h0);
        wr(8'h00, 32'h0);
        rchk("R2 revision read-only", 8'h00, 32'h18);
        wr(8'hFC, 32'h1234_5678);
        rchk("R2 unmapped read", 8'hFC, 32'h0);
        soft_reset();
        wr(8'h3C, 32'h0);

        // R3 alias set and clear for each aliased register
        for (int g = 0; g < 4; g++) begin
            logic [7:0] base, ca, sa;
            case (g)
                0: begin base = 8'h1C; ca = 8'h60; sa = 8'h64; end
                1: begin base = 8'h2C; ca = 8'h70; sa = 8'h74; end
                2: begin base = 8'h20; ca = 8'h80; sa = 8'h84; end
                default: begin base = 8'h3C; ca = 8'h90; sa = 8'h94; end
            endcase
            wr(base, 32'h0000_FF00);
            wr(sa, 32'h8000_0001);
            rchk($sformatf("R3 set @%h", base), base, 32'h8000_FF01);
            rchk($sformatf("R3 alias read @%h", sa), sa, 32'h8000_FF01);
            wr(ca, 32'h0000_0300);
            rchk($sformatf("R3 clear @%h", base), base, 32'h8000_FC01);
            rchk($sformatf("R3 alias read @%h", ca), ca, 32'h8000_FC01);
        end
        soft_reset();

        // R4 pad outputs qualified by direction
        wr(8'h3C, 32'hA5A5_5A5A);
        chk("R4 all inputs pad_out", pad_out, 32'h0);
        wr(8'h34, 32'hFFFF_0000);
        chk("R4 pad_oe", pad_oe, 32'h0000_FFFF);
        chk("R4 pad_out", pad_out, 32'h0000_5A5A);
        wr(8'h34, 32'h0);
        chk("R4 input to output shows stored value", pad_out, 32'hA5A5_5A5A);
        wr(8'h94, 32'h0000_0001);
        chk("R4 set alias at pad", pad_out, 32'hA5A5_5A5B);
        wr(8'h3C, 32'h0);
        soft_reset();

        // R5 R7 R8 detect-kind sweep over several lines
        for (int k = 0; k < 4; k++) begin
            for (int li = 0; li < 3; li++) begin
                int ln;
                logic [31:0] bit1, e0, e1, e2, e3, e4;
                logic [7:0] da;
                ln   = (li == 0) ? 0 : (li == 1) ? 13 : 31;
                bit1 = 32'h1 << ln;
                da   = (k == 0) ? 8'h40 : (k == 1) ? 8'h44 : (k == 2) ? 8'h48 : 8'h4C;
                e0 = (k == 0) ? bit1 : 32'h0;
                e1 = (k == 0 || k == 1 || k == 2) ? bit1 : 32'h0;
                e2 = (k == 1) ? bit1 : 32'h0;
                e3 = (k == 1 || k == 0 || k == 3) ? bit1 : 32'h0;
                e4 = (k == 0) ? bit1 : 32'h0;
                pins(32'h0);
                soft_reset();
                wr(8'h1C, 32'hFFFF_FFFF);
                wr(da, bit1);
                clr_all();
                for (int s = 0; s < 5; s++) begin
                    logic [31:0] ex;
                    if (s == 1) pins(bit1);
                    if (s == 2) clr_all();
                    if (s == 3) pins(32'h0);
                    if (s == 4) clr_all();
                    ex = (s == 0) ? e0 : (s == 1) ? e1 : (s == 2) ? e2 : (s == 3) ? e3 : e4;
                    rchk($sformatf("R5 R8 status-A kind%0d line%0d step%0d", k, ln, s), 8'h18, ex);
                    rchk($sformatf("R7 status-B kind%0d line%0d step%0d", k, ln, s), 8'h28, ex);
                    chk($sformatf("R7 irq_a kind%0d line%0d step%0d", k, ln, s),
                        {31'b0, irq_a}, {31'b0, ex != 0});
                    chk($sformatf("R7 irq_b masked kind%0d line%0d step%0d", k, ln, s),
                        {31'b0, irq_b}, 32'h0);
                end
            end
        end

        // R7 enable-B alone drives irq_b
        pins(32'h0);
        soft_reset();
        wr(8'h2C, 32'h0000_0004);
        wr(8'h48, 32'h0000_0006);
        pins(32'h0000_0002);
        chk("R7 irq_b other line", {31'b0, irq_b}, 32'h0);
        pins(32'h0000_0006);
        chk("R7 irq_b enabled line", {31'b0, irq_b}, 32'h1);
        chk("R7 irq_a no enable", {31'b0, irq_a}, 32'h0);

        // R8 partial clear, banks independent
        pins(32'h0);
        soft_reset();
        wr(8'h48, 32'hFFFF_FFFF);
        pins(32'h0000_0003);
        wr(8'h18, 32'h0000_0001);
        @(negedge clk);
        rchk("R8 partial clear A", 8'h18, 32'h0000_0002);
        rchk("R8 other bank untouched", 8'h28, 32'h0000_0003);

        // R6 output lines raise no events
        pins(32'h0);
        soft_reset();
        wr(8'h48, 32'hFFFF_FFFF);
        wr(8'h34, ~32'h0000_0008);
        clr_all();
        pins(32'h0000_0018);
        rchk("R6 output line ignored A", 8'h18, 32'h0000_0010);
        rchk("R6 output line ignored B", 8'h28, 32'h0000_0010);

        // R9 level re-evaluation on level and direction writes
        pins(32'h0);
        soft_reset();
        pins(32'h0000_0020);
        wr(8'h44, 32'h0000_0020);
        @(negedge clk);
        rchk("R9 level write re-arm A", 8'h18, 32'h0000_0020);
        rchk("R9 level write re-arm B", 8'h28, 32'h0000_0020);
        soft_reset();
        wr(8'h34, ~32'h0000_0040);
        pins(32'h0000_0060);
        wr(8'h44, 32'h0000_0040);
        @(negedge clk);
        rchk("R9 output line not re-armed", 8'h18, 32'h0);
        wr(8'h34, 32'hFFFF_FFFF);
        @(negedge clk);
        rchk("R9 direction write re-arm", 8'h18, 32'h0000_0040);

        // R10 wakeup condition sweep
        for (int c = 0; c < 9; c++) begin
            logic [31:0] cfg;
            logic expw;
            cfg = 32'h2 | ((c & 1) ? 32'h4 : 32'h0) | ((c & 2) ? 32'h8 : 32'h0);
            if (c == 8) cfg = 32'h2 | 32'h4 | 32'h10;
            expw = (c == 7) || (c == 8);
            pins(32'h0);
            wr(8'h10, cfg);
            if ((c & 4) || c == 8) wr(8'h84, 32'h1);
            wr(8'h48, 32'h1);
            pins(32'h1);
            chk($sformatf("R10 wake combo %0d", c), {31'b0, wake_req}, {31'b0, expw});
        end
        pins(32'h0);
        chk("R10 wake sticky after pad fall", {31'b0, wake_req}, 32'h1);
        clr_all();
        chk("R10 wake sticky after status clear", {31'b0, wake_req}, 32'h1);
        soft_reset();
        chk("R10 wake cleared by soft reset", {31'b0, wake_req}, 32'h0);

        // R11 soft reset restores defaults except data-out
        wr(8'h34, 32'h0000_00F0);
        wr(8'h3C, 32'h0000_0055);
        wr(8'h30, 32'h5);
        wr(8'h40, 32'h1);
        wr(8'h1C, 32'h3);
        wr(8'h20, 32'h7);
        wr(8'h54, 32'h9);
        wr(8'h10, 32'h0000_0002);
        chk("R11 pad_oe", pad_oe, 32'h0);
        rchk("R11 direction", 8'h34, 32'hFFFF_FFFF);
        rchk("R11 control", 8'h30, 32'h2);
        rchk("R11 level-low", 8'h40, 32'h0);
        rchk("R11 enable-A", 8'h1C, 32'h0);
        rchk("R11 wakeup mask", 8'h20, 32'h0);
        rchk("R11 debounce time", 8'h54, 32'h0);
        rchk("R11 sysconfig", 8'h10, 32'h0);
        rchk("R11 data-out kept", 8'h3C, 32'h0000_0055);
        wr(8'h10, 32'h0000_001F);
        rchk("R11 sysconfig mask with reset", 8'h10, 32'h0000_001D);

        // R12 synchronizer latency on data-in
        pins(32'h0);
        @(negedge clk);
        pad_in = 32'h0000_0009;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h38;
        @(negedge clk);
        chk("R12 first edge old", bus_rdata, 32'h0);
        @(negedge clk);
        chk("R12 second edge old", bus_rdata, 32'h0);
        @(negedge clk);
        chk("R12 third edge new", bus_rdata, 32'h0000_0009);
        bus_sel = 1'b0;
        pins(32'hA5A5_C33C);
        rchk("R12 data-in pattern", 8'h38, 32'hA5A5_C33C);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule